// File: doc/BRIEF.md
# Twenty-Stage Pipelined Salsa20 Hash Core

This block computes the 512-bit Salsa20 hash for a stream of 16-word input blocks and can take a new block on every clock cycle. The ten double rounds are split into twenty half-round stages. Each even stage (counting from 0) performs a column round and each odd stage performs a row round. A 512-bit register set sits after every stage.

Each block also carries an untouched copy of itself down the pipe. At the exit, this copy is added word by word, modulo 2^32, to the final state. A valid bit travels with every block. Idle cycles therefore pass through the pipe as bubbles and do not disturb the blocks around them.

The stream interface has valid signals only. There is no back-pressure: the producer may assert `in_valid` on any cycle, and the consumer must take every cycle in which `out_valid` is high, because a result is shown for exactly one cycle. Word `i` of a block occupies bits `[32*i+31:32*i]` on both the input and the output.

Top module: `salsa_hash_pipe`

## Requirements
- R1: While `rst_n` is low, and after its release until the first block has crossed the pipe, `out_valid` is 0.
- R2: A block sampled with `in_valid` high at rising edge n is driven on `hash_out` with `out_valid` high during the cycle after edge n+19. A consumer sampling at edge n+20 sees it, which is twenty cycles after loading.
- R3: Blocks presented on consecutive cycles emerge on consecutive cycles, in input order, one block per cycle.
- R4: A cycle with `in_valid` low produces exactly one cycle with `out_valid` low, twenty cycles later. The blocks on either side of such a bubble come out correct and in order.
- R5: Stage k with k even applies the quarterround to the word groups (0,4,8,12), (5,9,13,1), (10,14,2,6) and (15,3,7,11), with the arguments in that order.
- R6: Stage k with k odd applies the quarterround to the word groups (0,1,2,3), (5,6,7,4), (10,11,8,9) and (15,12,13,14), with the arguments in that order.
- R7: The quarterround on (a,b,c,d) updates b ^= rotl(a+d,7), then c ^= rotl(b+a,9), then d ^= rotl(c+b,13), then a ^= rotl(d+c,18). Each step uses the values already updated by the steps before it, and the sums are taken modulo 2^32.
- R8: `hash_out` word i is the final-state word i plus input word i, modulo 2^32.
- R9: Word i of a block is bits [32*i+31:32*i]. The all-zero input block hashes to the all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid bits |
| in_valid | input | 1 | A block is presented on `in_block` this cycle |
| in_block | input | 512 | Sixteen 32-bit input words, word i at bits [32i+31:32i] |
| out_valid | output | 1 | `hash_out` carries a finished hash this cycle |
| hash_out | output | 512 | Sixteen 32-bit hash words, same packing |

## Verification
The case hardest to reach from the ports is a result leaking into or being lost next to a bubble. Several irregular gap patterns must be in flight at the same time, so that stages holding valid blocks sit beside stages holding stale data. The stimulus mixes long back-to-back bursts, strictly alternating valid and idle cycles, and a pseudo-random valid pattern. A scoreboard stamps each expected hash with the cycle in which it must appear. Any shifted, duplicated or dropped result therefore shows up as a cycle or data mismatch against an independent software model of the hash.

// File: rtl/salsa_hash_pkg.sv
package salsa_hash_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned N_WORDS = 16;
  localparam int unsigned BLK_W = WORD_W * N_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] blk_t;

  // fixed rotation: pure wiring
  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/salsa_qround.sv
module salsa_qround
  import salsa_hash_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t b1, c1, d1, a1;

  // chained in-place updates, each using the freshest values
  assign b1 = b_i ^ rotl(a_i + d_i, 7);
  assign c1 = c_i ^ rotl(b1 + a_i, 9);
  assign d1 = d_i ^ rotl(c1 + b1, 13);
  assign a1 = a_i ^ rotl(d1 + c1, 18);

  assign a_o = a1;
  assign b_o = b1;
  assign c_o = c1;
  assign d_o = d1;

  always_comb begin
    if (a_i == '0 && b_i == '0 && c_i == '0 && d_i == '0)
      AST_QR_ZERO_FIXED: assert ({a1, b1, c1, d1} == '0); // R7
  end
endmodule

// File: rtl/salsa_half_round.sv
module salsa_half_round
  import salsa_hash_pkg::*;
#(
  parameter bit ROW_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic v_i,
  input  blk_t st_i,
  input  blk_t cp_i,
  output logic v_o,
  output blk_t st_o,
  output blk_t cp_o
);
  word_t nxt [N_WORDS];

  for (genvar g = 0; g < 4; g++) begin : g_grp
    localparam int unsigned I0 = ROW_MODE ? (4*g + (g % 4))     : (4*(g % 4) + g);
    localparam int unsigned I1 = ROW_MODE ? (4*g + ((g+1) % 4)) : (4*((g+1) % 4) + g);
    localparam int unsigned I2 = ROW_MODE ? (4*g + ((g+2) % 4)) : (4*((g+2) % 4) + g);
    localparam int unsigned I3 = ROW_MODE ? (4*g + ((g+3) % 4)) : (4*((g+3) % 4) + g);
    word_t w0, w1, w2, w3;
    salsa_qround u_qr (
      .a_i(st_i[I0]), .b_i(st_i[I1]), .c_i(st_i[I2]), .d_i(st_i[I3]),
      .a_o(w0), .b_o(w1), .c_o(w2), .d_o(w3)
    );
    assign nxt[I0] = w0;
    assign nxt[I1] = w1;
    assign nxt[I2] = w2;
    assign nxt[I3] = w3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  // data registers carry no reset; the valid bit qualifies them
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_WORDS; i++) st_o[i] <= nxt[i];
    cp_o <= cp_i;
  end
endmodule

// File: rtl/salsa_feedfwd.sv
module salsa_feedfwd
  import salsa_hash_pkg::*;
(
  input  blk_t st_i,
  input  blk_t cp_i,
  output blk_t sum_o
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_add
    assign sum_o[w] = st_i[w] + cp_i[w];
  end
endmodule

// File: rtl/salsa_hash_pipe.sv
module salsa_hash_pipe
  import salsa_hash_pkg::*;
#(
  parameter int unsigned ROUNDS = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [511:0]   in_block,
  output logic           out_valid,
  output logic [511:0]   hash_out
);
  localparam int unsigned CW = $clog2(ROUNDS + 1);
  localparam int unsigned IW = $clog2(ROUNDS + 2);

  logic [ROUNDS:0] vld;
  blk_t st [ROUNDS+1];
  blk_t cp [ROUNDS+1];
  blk_t sum;

  assign vld[0] = in_valid;
  assign st[0]  = blk_t'(in_block);
  assign cp[0]  = blk_t'(in_block);

  for (genvar r = 0; r < ROUNDS; r++) begin : g_stage
    salsa_half_round #(.ROW_MODE(r % 2 == 1)) u_hr (
      .clk(clk), .rst_n(rst_n),
      .v_i(vld[r]), .st_i(st[r]), .cp_i(cp[r]),
      .v_o(vld[r+1]), .st_o(st[r+1]), .cp_o(cp[r+1])
    );
  end

  salsa_feedfwd u_ff (.st_i(st[ROUNDS]), .cp_i(cp[ROUNDS]), .sum_o(sum));

  assign out_valid = vld[ROUNDS];
  assign hash_out  = sum;

  // ---- checking state ----
  logic [CW-1:0] since_rst;
  logic [CW-1:0] gap_cnt;
  logic [IW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      gap_cnt   <= CW'(ROUNDS);
      inflight  <= '0;
    end else begin
      if (since_rst < CW'(ROUNDS)) since_rst <= since_rst + CW'(1);
      if (in_valid)                    gap_cnt <= '0;
      else if (gap_cnt < CW'(ROUNDS))  gap_cnt <= gap_cnt + CW'(1);
      inflight <= inflight + IW'(in_valid) - IW'(out_valid);
    end
  end

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> since_rst >= CW'(ROUNDS)); // R1

  AST_OUT_NEEDS_RECENT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> gap_cnt <= CW'(ROUNDS - 1)); // R2

  AST_INFLIGHT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inflight) == $countones(vld[ROUNDS:1])); // R4

  AST_IDLE_PIPE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == '0) |-> !out_valid); // R3
endmodule

// File: tb/salsa_hash_pipe_tb_top.sv
module salsa_hash_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [511:0] in_block = '0;
  logic out_valid;
  logic [511:0] hash_out;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [511:0] exp_q[$];
  int cyc_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  salsa_hash_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .out_valid(out_valid), .hash_out(hash_out)
  );

  // independent model written from the requirements
  localparam int COLS[16] = '{0,4,8,12, 5,9,13,1, 10,14,2,6, 15,3,7,11};
  localparam int ROWS[16] = '{0,1,2,3, 5,6,7,4, 10,11,8,9, 15,12,13,14};

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [511:0] model(input logic [511:0] blk);
    logic [31:0] s[16];
    logic [31:0] x[16];
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin
      x[i] = blk[32*i +: 32];
      s[i] = x[i];
    end
    for (int k = 0; k < LAT; k++) begin
      for (int g = 0; g < 4; g++) begin
        int a, b, c, d;
        a = (k % 2 == 0) ? COLS[4*g]   : ROWS[4*g];
        b = (k % 2 == 0) ? COLS[4*g+1] : ROWS[4*g+1];
        c = (k % 2 == 0) ? COLS[4*g+2] : ROWS[4*g+2];
        d = (k % 2 == 0) ? COLS[4*g+3] : ROWS[4*g+3];
        s[b] = s[b] ^ rl(s[a] + s[d], 7);
        s[c] = s[c] ^ rl(s[b] + s[a], 9);
        s[d] = s[d] ^ rl(s[c] + s[b], 13);
        s[a] = s[a] ^ rl(s[d] + s[c], 18);
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = s[i] + x[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic send(input logic [511:0] blk);
    @(negedge clk);
    in_valid = 1'b1;
    in_block = blk;
    exp_q.push_back(model(blk));
    cyc_q.push_back(cyc + LAT);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_block = {16{32'hDEAD_0000 + i}};
    end
  endtask

  function automatic logic [511:0] rnd_blk();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  // monitor: pops expected items and compares data and arrival cycle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, $sformatf("R4 out_valid with nothing expected at cycle %0d act=1 exp=0", cyc));
      end else begin
        logic [511:0] e;
        int ec;
        e = exp_q.pop_front();
        ec = cyc_q.pop_front();
        // R2 R3: arrival cycle
        check(ec == cyc, $sformatf("R2 R3 arrival cycle act=%0d exp=%0d", cyc, ec));
        // R5 R6 R7 R8 R9: hash value
        check(hash_out == e, $sformatf("R5 R6 R7 R8 R9 hash act=%h exp=%h", hash_out, e));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [511:0] b;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, $sformatf("R1 out_valid in reset act=%b exp=0", out_valid));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, $sformatf("R1 out_valid after reset act=%b exp=0", out_valid));

    // R9: zero block is a fixed point
    send('0);
    idle(LAT + 3);
    check(exp_q.size() == 0, $sformatf("R2 single block drained act=%0d exp=0", exp_q.size()));

    // R8: all ones and a counting pattern
    send('1);
    for (int i = 0; i < 16; i++) b[32*i +: 32] = 32'h0101_0101 * i;
    send(b);
    idle(LAT + 2);

    // R3: long back-to-back burst
    for (int i = 0; i < 30; i++) send(rnd_blk());
    // R4: strictly alternating bubbles
    for (int i = 0; i < 20; i++) begin
      send(rnd_blk());
      idle(1);
    end
    // R4: irregular valid pattern
    for (int i = 0; i < 80; i++) begin
      if ($urandom % 3 != 0) send(rnd_blk());
      else idle(1 + ($urandom % 3));
    end
    // single-bit inputs exercise every word slot (R5 R6)
    for (int w = 0; w < 16; w++) begin
      b = '0;
      b[32*w] = 1'b1;
      send(b);
    end
    idle(LAT + 5);

    check(exp_q.size() == 0, $sformatf("R3 R4 results outstanding act=%0d exp=0", exp_q.size()));
    check(out_valid == 1'b0, $sformatf("R4 idle pipe output act=%b exp=0", out_valid));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule